// File: doc/BRIEF.md
# 8-bit CPU Memory Bank Mapper

This block decodes the 16-bit address bus of an 8-bit processor into chip selects and an 18-bit physical address for an external RAM. The processor sees 64 KB. Below 0x8000 it reaches RAM directly. Between 0x8000 and 0xBFFF there is a 16 KB window, and a 4-bit bank register chooses which 16 KB-aligned chunk of the 256 KB physical space appears there. The chosen chunk may be one that is also visible through the linear map.

The top of the space holds a boot flash overlay, and a shadow bit switches it. While the bit is set, reads in that region come from flash. Writes to the same addresses always land in the RAM underneath, so start-up code can copy itself into RAM and then clear the bit. The page 0xFE00–0xFEFF is always an I/O page and is cut into ten peripheral strobes.

The bank register and the shadow bit are the only state in the block. Each is loaded by its own synchronous strobe. Every other output is a combinational function of the address, the read/write line and that state.

Top module: `mmap_decoder`

## Requirements
- R1: For addresses 0x0000–0x7FFF, ram_ce is 1 and ram_addr equals the CPU address, with bits 17:16 at zero.
- R2: For addresses 0x8000–0xBFFF, ram_ce is 1 and ram_addr is {bank_q, addr[13:0]}, for every bank value 0 to 15.
- R3: For addresses in 0xC000–0xFDFF and 0xFF00–0xFFFF that go to RAM, ram_addr equals the CPU address with bits 17:16 at zero.
- R4: For addresses 0xFE00–0xFEFF, io_sel is 1 and both ram_ce and flash_ce are 0. Exactly one strobe bit is set, chosen by addr[7:4]: nibbles 0–3 select bits 0–3, nibbles 4–5 select bit 4, nibbles 6–9 select bits 5–8, and nibbles A–F select bit 9. Outside this page all strobes are 0.
- R5: While shadow_q is 1, a read (cpu_rd=1) in 0xC000–0xFDFF or 0xFF00–0xFFFF sets flash_ce to 1 and ram_ce to 0. flash_addr always equals addr[13:0].
- R6: While shadow_q is 1, a write (cpu_rd=0) in those same ranges sets ram_ce and ram_we to 1, flash_ce to 0, and ram_addr to the CPU address.
- R7: While shadow_q is 0, both reads and writes in those ranges go to RAM, and flash_ce stays 0.
- R8: On a clock edge with rst high, bank_q becomes 0 and shadow_q becomes 1.
- R9: On a clock edge with bank_we high, bank_q takes bank_d. On a clock edge with shadow_we high, shadow_q takes shadow_d. Each strobe leaves the other field unchanged.
- R10: At most one of ram_ce, flash_ce and io_sel is 1 at a time, and flash_ce is 1 only on read cycles.
- R11: ram_we equals ram_ce on write cycles and is 0 otherwise. mem_oe is 1 on a read cycle whenever any of ram_ce, flash_ce or io_sel is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| bank_we | input | 1 | Load strobe for the bank register |
| bank_d | input | 4 | New bank value |
| shadow_we | input | 1 | Load strobe for the shadow bit |
| shadow_d | input | 1 | New shadow value |
| ram_ce | output | 1 | RAM chip enable |
| ram_we | output | 1 | RAM write enable |
| mem_oe | output | 1 | Read output enable |
| ram_addr | output | 18 | Physical RAM address |
| flash_ce | output | 1 | Flash chip enable |
| flash_addr | output | 14 | Flash address |
| io_sel | output | 1 | I/O page select |
| io_strobe | output | 10 | Per-peripheral strobes |
| bank_q | output | 4 | Current bank register |
| shadow_q | output | 1 | Current shadow bit |

## Verification
A wrong bank value shows up on the next access inside the window as wrong bits 17:14 of ram_addr. Because bank_q is also a port, it is visible in the very cycle after the load edge. A stuck or wrongly reset shadow bit turns flash reads in the top region into RAM reads, or the reverse, and shows as a swap of flash_ce and ram_ce on the first such read. Every 256-byte page is visited with several bank values and both shadow settings, so a fault in the region edges or the strobe map shows up in the page where it occurs.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
    localparam int CPU_AW  = 16;
    localparam int BANK_W  = 4;
    localparam int WIN_W   = 14;
    localparam int PHYS_AW = WIN_W + BANK_W;
    localparam int IO_N    = 10;
    localparam int IDX_W   = $clog2(IO_N);
    localparam logic [7:0] IO_PAGE = 8'hFE;

    typedef enum logic [1:0] {
        RGN_LOW  = 2'd0,
        RGN_WIN  = 2'd1,
        RGN_HIGH = 2'd2,
        RGN_IO   = 2'd3
    } region_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              shadow;
    } cfg_t;

    typedef struct packed {
        logic ram;
        logic flash;
        logic io;
    } sel_t;

    // map the upper offset nibble inside the I/O page to a strobe index
    function automatic logic [IDX_W-1:0] io_index(input logic [3:0] nib);
        if (nib < 4'd4)       return IDX_W'(nib);
        else if (nib < 4'd6)  return IDX_W'(4);
        else if (nib < 4'd10) return IDX_W'(nib - 4'd1);
        else                  return IDX_W'(IO_N - 1);
    endfunction
endpackage

// File: rtl/mmap_cfg_regs.sv
module mmap_cfg_regs
    import mmap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bank_we,
    input  logic [BANK_W-1:0] bank_d,
    input  logic              shadow_we,
    input  logic              shadow_d,
    output cfg_t              cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.bank   <= '0;
            cfg.shadow <= 1'b1;
        end else begin
            if (bank_we)   cfg.bank   <= bank_d;
            if (shadow_we) cfg.shadow <= shadow_d;
        end
    end
endmodule

// File: rtl/mmap_region.sv
module mmap_region
    import mmap_pkg::*;
(
    input  logic [7:0] addr_hi,
    output region_e    region
);
    always_comb begin
        if (!addr_hi[7])             region = RGN_LOW;
        else if (!addr_hi[6])        region = RGN_WIN;
        else if (addr_hi == IO_PAGE) region = RGN_IO;
        else                         region = RGN_HIGH;
    end
endmodule

// File: rtl/mmap_io_decode.sv
module mmap_io_decode
    import mmap_pkg::*;
#(
    parameter int N = IO_N
) (
    input  logic         en,
    input  logic [3:0]   nib,
    output logic [N-1:0] strobe
);
    logic [IDX_W-1:0] idx;
    assign idx = io_index(nib);

    for (genvar i = 0; i < N; i++) begin : g_strobe
        assign strobe[i] = en && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
    import mmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic               cpu_rd,
    input  logic               bank_we,
    input  logic [BANK_W-1:0]  bank_d,
    input  logic               shadow_we,
    input  logic               shadow_d,
    output logic               ram_ce,
    output logic               ram_we,
    output logic               mem_oe,
    output logic [PHYS_AW-1:0] ram_addr,
    output logic               flash_ce,
    output logic [WIN_W-1:0]   flash_addr,
    output logic               io_sel,
    output logic [IO_N-1:0]    io_strobe,
    output logic [BANK_W-1:0]  bank_q,
    output logic               shadow_q
);
    cfg_t    cfg;
    region_e region;
    sel_t    sel;

    mmap_cfg_regs i_cfg (
        .clk       (clk),
        .rst       (rst),
        .bank_we   (bank_we),
        .bank_d    (bank_d),
        .shadow_we (shadow_we),
        .shadow_d  (shadow_d),
        .cfg       (cfg)
    );

    mmap_region i_region (
        .addr_hi (cpu_addr[CPU_AW-1 -: 8]),
        .region  (region)
    );

    mmap_io_decode #(.N(IO_N)) i_io (
        .en     (sel.io),
        .nib    (cpu_addr[7:4]),
        .strobe (io_strobe)
    );

    always_comb begin
        sel      = '0;
        ram_addr = {{(PHYS_AW-CPU_AW){1'b0}}, cpu_addr};
        unique case (region)
            RGN_LOW:  sel.ram = 1'b1;
            RGN_WIN: begin
                sel.ram  = 1'b1;
                ram_addr = {cfg.bank, cpu_addr[WIN_W-1:0]};
            end
            RGN_HIGH: begin
                if (cfg.shadow && cpu_rd) sel.flash = 1'b1;
                else                      sel.ram   = 1'b1;
            end
            RGN_IO:   sel.io = 1'b1;
            default:  sel = '0;
        endcase
    end

    assign ram_ce     = sel.ram;
    assign flash_ce   = sel.flash;
    assign io_sel     = sel.io;
    assign ram_we     = sel.ram && !cpu_rd;
    assign mem_oe     = cpu_rd && (sel.ram || sel.flash || sel.io);
    assign flash_addr = cpu_addr[WIN_W-1:0];
    assign bank_q     = cfg.bank;
    assign shadow_q   = cfg.shadow;
endmodule

// File: rtl/mmap_decoder_chk.sv
module mmap_decoder_chk
    import mmap_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [CPU_AW-1:0]  cpu_addr,
    input logic               cpu_rd,
    input logic               bank_we,
    input logic [BANK_W-1:0]  bank_d,
    input logic               shadow_we,
    input logic               shadow_d,
    input logic               ram_ce,
    input logic               ram_we,
    input logic               mem_oe,
    input logic [PHYS_AW-1:0] ram_addr,
    input logic               flash_ce,
    input logic [WIN_W-1:0]   flash_addr,
    input logic               io_sel,
    input logic [IO_N-1:0]    io_strobe,
    input logic [BANK_W-1:0]  bank_q,
    input logic               shadow_q
);
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_ce, flash_ce, io_sel}));

    a_r10_flash_on_read: assert property (@(posedge clk) disable iff (rst)
        flash_ce |-> cpu_rd);

    a_r2_window_addr: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] == 2'b10) |-> (ram_ce && ram_addr[PHYS_AW-1:WIN_W] == bank_q));

    a_r1_low_linear: assert property (@(posedge clk) disable iff (rst)
        !cpu_addr[15] |-> (ram_ce && ram_addr == {2'b00, cpu_addr}));

    a_r4_io_onehot: assert property (@(posedge clk) disable iff (rst)
        io_sel |-> ($countones(io_strobe) == 1 && !ram_ce && !flash_ce));

    a_r5_flash_read: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && shadow_q && cpu_addr[15:14] == 2'b11 && cpu_addr[15:8] != 8'hFE)
            |-> (flash_ce && !ram_ce));

    a_r9_bank_load: assert property (@(posedge clk) disable iff (rst)
        (bank_we && !shadow_we) |=> (bank_q == $past(bank_d) && $stable(shadow_q)));

    a_r11_write_enable: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_ce && !cpu_rd && !mem_oe));
endmodule

bind mmap_decoder mmap_decoder_chk i_chk (.*);

// File: tb/test_mmap_decoder.sv
module test_mmap_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b1;
    logic        bank_we = 1'b0;
    logic [3:0]  bank_d = '0;
    logic        shadow_we = 1'b0;
    logic        shadow_d = 1'b0;
    logic        ram_ce, ram_we, mem_oe, flash_ce, io_sel, shadow_q;
    logic [17:0] ram_addr;
    logic [13:0] flash_addr;
    logic [9:0]  io_strobe;
    logic [3:0]  bank_q;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    mmap_decoder i_mmap_decoder (.*);

    typedef struct packed {
        logic [15:0] addr;
        logic        rd;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 1'b1}, '{16'h7FFF, 1'b0}, '{16'h8000, 1'b1}, '{16'hBFFF, 1'b0},
        '{16'hC000, 1'b1}, '{16'hC000, 1'b0}, '{16'hFDFF, 1'b1}, '{16'hFE00, 1'b1},
        '{16'hFE1F, 1'b0}, '{16'hFE2A, 1'b1}, '{16'hFE3F, 1'b1}, '{16'hFE40, 1'b0},
        '{16'hFE5F, 1'b1}, '{16'hFE65, 1'b1}, '{16'hFE7E, 1'b0}, '{16'hFE81, 1'b1},
        '{16'hFE9C, 1'b1}, '{16'hFEA0, 1'b0}, '{16'hFEFF, 1'b1}, '{16'hFF00, 1'b0}
    };

    // independent reference: {ram_ce, ram_we, flash_ce, io_sel, mem_oe, ram_addr, flash_addr, strobe}
    function automatic logic [46:0] model(logic [15:0] a, logic rd, logic [3:0] bk, logic sh);
        logic r, f, io, w, oe;
        logic [17:0] pa;
        logic [9:0]  st;
        r = 0; f = 0; io = 0; st = '0;
        pa = {2'b00, a};
        if (a <= 16'h7FFF) r = 1;
        else if (a <= 16'hBFFF) begin r = 1; pa = {bk, a[13:0]}; end
        else if (a >= 16'hFE00 && a <= 16'hFEFF) begin
            io = 1;
            case (a[7:4])
                4'h0: st[0] = 1;  4'h1: st[1] = 1;  4'h2: st[2] = 1;  4'h3: st[3] = 1;
                4'h4, 4'h5: st[4] = 1;
                4'h6: st[5] = 1;  4'h7: st[6] = 1;  4'h8: st[7] = 1;  4'h9: st[8] = 1;
                default: st[9] = 1;
            endcase
        end
        else if (sh && rd) f = 1;
        else r = 1;
        w  = r && !rd;
        oe = rd && (r || f || io);
        return {r, w, f, io, oe, pa, a[13:0], st};
    endfunction

    function automatic string req_of(logic [15:0] a, logic rd, logic sh);
        if (a <= 16'h7FFF) return "R1";
        if (a <= 16'hBFFF) return "R2";
        if (a[15:8] == 8'hFE) return "R4";
        if (!sh) return "R7/R3";
        return rd ? "R5" : "R6/R3";
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [46:0] outs();
        return {ram_ce, ram_we, flash_ce, io_sel, mem_oe, ram_addr, flash_addr, io_strobe};
    endfunction

    task automatic access(logic [15:0] a, logic rd, logic [3:0] bk, logic sh);
        @(negedge clk);
        cpu_addr = a;
        cpu_rd   = rd;
        #1;
        chk(req_of(a, rd, sh), 64'(outs()), 64'(model(a, rd, bk, sh)));
        // R10 / R11 invariants at the ports
        chk("R10", 64'($countones({ram_ce, flash_ce, io_sel}) <= 1 && !(flash_ce && !rd)), 64'(1));
        chk("R11", 64'({ram_we, mem_oe}), 64'({ram_ce && !rd, rd && (ram_ce || flash_ce || io_sel)}));
    endtask

    task automatic set_cfg(logic [3:0] bk, logic sh);
        @(negedge clk);
        bank_we = 1; bank_d = bk; shadow_we = 1; shadow_d = sh;
        @(negedge clk);
        bank_we = 0; shadow_we = 0;
    endtask

    localparam logic [3:0] BANKS [3] = '{4'd0, 4'd6, 4'd15};

    initial begin
        #(100000 * 10);
        if (!done) begin
            nfail++; nchk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R8", 64'({bank_q, shadow_q}), 64'({4'd0, 1'b1}));
        access(16'hC123, 1'b1, 4'd0, 1'b1);
        access(16'h8123, 1'b1, 4'd0, 1'b1);

        // vector table across shadow settings and banks
        for (int s = 1; s >= 0; s--) begin
            for (int b = 0; b < 3; b++) begin
                set_cfg(BANKS[b], s[0]);
                for (int v = 0; v < NV; v++)
                    access(VECS[v].addr, VECS[v].rd, BANKS[b], s[0]);
            end
        end

        // every page, both shadow settings, several banks, both directions
        for (int s = 0; s < 2; s++) begin
            for (int b = 0; b < 3; b++) begin
                set_cfg(BANKS[b], s[0]);
                for (int p = 0; p < 256; p++) begin
                    access({p[7:0], 8'((p * 37) & 8'hFF)}, 1'b1, BANKS[b], s[0]);
                    access({p[7:0], 8'((p * 91) & 8'hFF)}, 1'b0, BANKS[b], s[0]);
                end
            end
        end

        // R2: every bank value, window aliasing linear RAM
        for (int b = 0; b < 16; b++) begin
            set_cfg(b[3:0], 1'b1);
            access(16'hA5A5, 1'b1, b[3:0], 1'b1);
        end

        // R9: independent strobes
        set_cfg(4'd3, 1'b1);
        @(negedge clk); bank_we = 1; bank_d = 4'd12;
        @(negedge clk); bank_we = 0; #1;
        chk("R9", 64'({bank_q, shadow_q}), 64'({4'd12, 1'b1}));
        @(negedge clk); shadow_we = 1; shadow_d = 0;
        @(negedge clk); shadow_we = 0; #1;
        chk("R9", 64'({bank_q, shadow_q}), 64'({4'd12, 1'b0}));
        access(16'hE000, 1'b1, 4'd12, 1'b0);

        // R8: reset after configuration restores defaults
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0; #1;
        chk("R8", 64'({bank_q, shadow_q}), 64'({4'd0, 1'b1}));
        access(16'hFFFC, 1'b1, 4'd0, 1'b1);
        access(16'h9000, 1'b0, 4'd0, 1'b1);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule